// File: doc/BRIEF.md
# Two-Level Trap Context Save Stack

This block keeps the machine trap context: the exception PC, the trap cause, the previous interrupt-enable bit, the previous privilege, the current trap type and the previous trap type. Each stacked field has a live register and two shadow copies behind it. A trap-entry strobe pushes every field one level deeper and loads the new trap's values. A trap-return strobe pops every field one level back. It also reports the PC and privilege to resume with, and the value the core's global interrupt enable should take.

Three levels of context are held in all: the live register and two shadows. An exception taken inside an NMI handler, an NMI taken inside an exception handler, or an exception taken inside another exception can therefore nest two deep and still return cleanly to the original program. The interrupt enable itself lives in the core. This block only issues a one-cycle write request for it: clear it on entry, and restore it on return.

Top module: `trap_ctx_stack`

## Requirements
- R1: After reset, every PC and cause level is zero. Every interrupt-enable level is 1. Every privilege level is 2'b11 (machine). The trap type and all previous-type levels are zero. `ret_valid` and `mie_we` are low.
- R2: One clock after `trap_take`, `epc` holds `trap_pc`, `epc_sv1` holds the old `epc`, and `epc_sv2` holds the old `epc_sv1`.
- R3: One clock after `trap_take`, `cause` holds `trap_cause`, and the old cause values move one level deeper in the same way as the PC.
- R4: One clock after `trap_take`, `pie` holds `cur_mie` and `ppriv` holds `cur_priv`. The old values of both move one level deeper. `mie_we` is 1 with `mie_wdata` 0 for exactly that cycle.
- R5: One clock after `trap_take`, `ttype` holds `trap_type` and `pttype` holds the old `ttype`. The old previous types move one level deeper.
- R6: One clock after `trap_ret` (without `trap_take`), `ret_valid` is 1 for one cycle. At that point `ret_pc` equals the `epc` that was live before the return, and `ret_priv` equals the `ppriv` that was live before it. `mie_we` is 1 with `mie_wdata` equal to the `pie` that was live before it. `ttype` takes the old `pttype`.
- R7: On a return, every stacked field moves one level back toward the live register. The second-level slots are refilled with the R1 reset values.
- R8: When `trap_take` and `trap_ret` are both high in one cycle, only the entry of R2–R5 is performed and `ret_valid` stays low.
- R9: A third nested entry while all three levels are occupied discards the oldest context. A later chain of returns yields the three newest PCs, newest first, followed by zero.
- R10: With neither strobe high, every stacked field holds its value and `ret_valid` and `mie_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| trap_take | input | 1 | Trap entry strobe |
| trap_ret | input | 1 | Trap return strobe |
| trap_pc | input | XLEN | PC of the trapping instruction |
| trap_cause | input | CAUSE_W | Cause of the new trap |
| trap_type | input | TYPE_W | Type code of the new trap |
| cur_mie | input | 1 | Core interrupt enable at entry |
| cur_priv | input | 2 | Core privilege at entry |
| epc | output | XLEN | Live exception PC |
| epc_sv1 | output | XLEN | First shadow PC |
| epc_sv2 | output | XLEN | Second shadow PC |
| cause | output | CAUSE_W | Live cause |
| cause_sv1 | output | CAUSE_W | First shadow cause |
| cause_sv2 | output | CAUSE_W | Second shadow cause |
| pie | output | 1 | Live previous interrupt enable |
| pie_sv1 | output | 1 | First shadow interrupt enable |
| pie_sv2 | output | 1 | Second shadow interrupt enable |
| ppriv | output | 2 | Live previous privilege |
| ppriv_sv1 | output | 2 | First shadow privilege |
| ppriv_sv2 | output | 2 | Second shadow privilege |
| ttype | output | TYPE_W | Type of trap being handled |
| pttype | output | TYPE_W | Live previous trap type |
| pttype_sv1 | output | TYPE_W | First shadow previous type |
| pttype_sv2 | output | TYPE_W | Second shadow previous type |
| ret_valid | output | 1 | Return results valid pulse |
| ret_pc | output | XLEN | PC to resume at |
| ret_priv | output | 2 | Privilege to resume in |
| mie_we | output | 1 | Interrupt-enable write request |
| mie_wdata | output | 1 | Interrupt-enable write value |

## Verification
Every result of this block is registered. The state after a strobe, the return pulse and the enable write request therefore all appear one clock after the rising edge at which the strobe was sampled. The driver changes inputs on falling edges and queues the full expected state for that edge. The monitor pops and compares one queued item one nanosecond after each rising edge, so each comparison falls inside the cycle in which the result is due. Chains of four entries and four returns check the ordering across all three levels.

// File: rtl/trap_ctx_stack.sv
module trap_ctx_stack #(
  parameter int XLEN    = 32,
  parameter int CAUSE_W = 12,
  parameter int TYPE_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               trap_take,
  input  logic               trap_ret,
  input  logic [XLEN-1:0]    trap_pc,
  input  logic [CAUSE_W-1:0] trap_cause,
  input  logic [TYPE_W-1:0]  trap_type,
  input  logic               cur_mie,
  input  logic [1:0]         cur_priv,
  output logic [XLEN-1:0]    epc,
  output logic [XLEN-1:0]    epc_sv1,
  output logic [XLEN-1:0]    epc_sv2,
  output logic [CAUSE_W-1:0] cause,
  output logic [CAUSE_W-1:0] cause_sv1,
  output logic [CAUSE_W-1:0] cause_sv2,
  output logic               pie,
  output logic               pie_sv1,
  output logic               pie_sv2,
  output logic [1:0]         ppriv,
  output logic [1:0]         ppriv_sv1,
  output logic [1:0]         ppriv_sv2,
  output logic [TYPE_W-1:0]  ttype,
  output logic [TYPE_W-1:0]  pttype,
  output logic [TYPE_W-1:0]  pttype_sv1,
  output logic [TYPE_W-1:0]  pttype_sv2,
  output logic               ret_valid,
  output logic [XLEN-1:0]    ret_pc,
  output logic [1:0]         ret_priv,
  output logic               mie_we,
  output logic               mie_wdata
);
  localparam int LV = 3;
  localparam logic [1:0] PRIV_M = 2'b11;

  logic [XLEN-1:0]    epc_q   [LV];
  logic [CAUSE_W-1:0] cause_q [LV];
  logic               pie_q   [LV];
  logic [1:0]         ppriv_q [LV];
  logic [TYPE_W-1:0]  pt_q    [LV];
  logic [TYPE_W-1:0]  typ_q;

  wire push = trap_take;
  wire pop  = trap_ret & ~trap_take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LV; i++) begin
        epc_q[i]   <= '0;
        cause_q[i] <= '0;
        pie_q[i]   <= 1'b1;
        ppriv_q[i] <= PRIV_M;
        pt_q[i]    <= '0;
      end
      typ_q     <= '0;
      ret_valid <= 1'b0;
      ret_pc    <= '0;
      ret_priv  <= PRIV_M;
      mie_we    <= 1'b0;
      mie_wdata <= 1'b0;
    end else begin
      ret_valid <= 1'b0;
      mie_we    <= 1'b0;
      if (push) begin
        for (int i = LV-1; i > 0; i--) begin
          epc_q[i]   <= epc_q[i-1];
          cause_q[i] <= cause_q[i-1];
          pie_q[i]   <= pie_q[i-1];
          ppriv_q[i] <= ppriv_q[i-1];
          pt_q[i]    <= pt_q[i-1];
        end
        epc_q[0]   <= trap_pc;
        cause_q[0] <= trap_cause;
        pie_q[0]   <= cur_mie;
        ppriv_q[0] <= cur_priv;
        pt_q[0]    <= typ_q;
        typ_q      <= trap_type;
        mie_we     <= 1'b1;
        mie_wdata  <= 1'b0;
      end else if (pop) begin
        for (int i = 0; i < LV-1; i++) begin
          epc_q[i]   <= epc_q[i+1];
          cause_q[i] <= cause_q[i+1];
          pie_q[i]   <= pie_q[i+1];
          ppriv_q[i] <= ppriv_q[i+1];
          pt_q[i]    <= pt_q[i+1];
        end
        epc_q[LV-1]   <= '0;
        cause_q[LV-1] <= '0;
        pie_q[LV-1]   <= 1'b1;
        ppriv_q[LV-1] <= PRIV_M;
        pt_q[LV-1]    <= '0;
        typ_q     <= pt_q[0];
        ret_valid <= 1'b1;
        ret_pc    <= epc_q[0];
        ret_priv  <= ppriv_q[0];
        mie_we    <= 1'b1;
        mie_wdata <= pie_q[0];
      end
    end
  end

  assign epc        = epc_q[0];
  assign epc_sv1    = epc_q[1];
  assign epc_sv2    = epc_q[2];
  assign cause      = cause_q[0];
  assign cause_sv1  = cause_q[1];
  assign cause_sv2  = cause_q[2];
  assign pie        = pie_q[0];
  assign pie_sv1    = pie_q[1];
  assign pie_sv2    = pie_q[2];
  assign ppriv      = ppriv_q[0];
  assign ppriv_sv1  = ppriv_q[1];
  assign ppriv_sv2  = ppriv_q[2];
  assign ttype      = typ_q;
  assign pttype     = pt_q[0];
  assign pttype_sv1 = pt_q[1];
  assign pttype_sv2 = pt_q[2];

  // R2
  entry_pc_chain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> epc == $past(trap_pc) && epc_sv1 == $past(epc) && epc_sv2 == $past(epc_sv1));

  // R4
  entry_mie_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trap_take |=> mie_we && !mie_wdata && pie == $past(cur_mie) && ppriv == $past(cur_priv));

  // R6
  ret_outputs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_take) |=> ret_valid && ret_pc == $past(epc) && ret_priv == $past(ppriv)
                                 && ttype == $past(pttype));

  // R7
  pop_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_ret && !trap_take) |=> epc_sv2 == '0 && cause_sv2 == '0 && pie_sv2 && ppriv_sv2 == PRIV_M
                                 && epc == $past(epc_sv1));

  // R8
  entry_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (trap_take && trap_ret) |=> !ret_valid && epc == $past(trap_pc));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!trap_take && !trap_ret) |=> !ret_valid && !mie_we && $stable(epc) && $stable(epc_sv2)
                                  && $stable(cause) && $stable(ttype));
endmodule

// File: tb/sim_trap_ctx_stack.sv
`timescale 1ns/1ps
module sim_trap_ctx_stack;
  logic clk = 1'b0, rst_n = 1'b0;
  logic trap_take = 0, trap_ret = 0, cur_mie = 0;
  logic [31:0] trap_pc = 0;
  logic [11:0] trap_cause = 0;
  logic [1:0]  trap_type = 0, cur_priv = 0;
  logic [31:0] epc, epc_sv1, epc_sv2, ret_pc;
  logic [11:0] cause, cause_sv1, cause_sv2;
  logic pie, pie_sv1, pie_sv2, ret_valid, mie_we, mie_wdata;
  logic [1:0] ppriv, ppriv_sv1, ppriv_sv2, ttype, pttype, pttype_sv1, pttype_sv2, ret_priv;

  always #2.5 clk = ~clk;

  trap_ctx_stack u0 (.*);

  typedef struct {
    logic [31:0] e[3]; logic [11:0] c[3]; logic p[3]; logic [1:0] v[3];
    logic [1:0] t; logic [1:0] pt[3];
    logic rv; logic [31:0] rpc; logic [1:0] rpr; logic we; logic wd;
    string tg_pc, tg_ca, tg_st, tg_ty, tg_out;
  } exp_t;

  exp_t q[$];
  exp_t m;
  int checks = 0, errors = 0;

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic op(bit take, bit ret, logic [31:0] pc, logic [11:0] ca, logic [1:0] ty,
                    bit mie, logic [1:0] pr, string tag);
    @(negedge clk);
    trap_take = take; trap_ret = ret; trap_pc = pc; trap_cause = ca;
    trap_type = ty; cur_mie = mie; cur_priv = pr;
    m.rv = 0; m.we = 0;
    if (take) begin
      for (int i = 2; i > 0; i--) begin
        m.e[i] = m.e[i-1]; m.c[i] = m.c[i-1]; m.p[i] = m.p[i-1];
        m.v[i] = m.v[i-1]; m.pt[i] = m.pt[i-1];
      end
      m.e[0] = pc; m.c[0] = ca; m.p[0] = mie; m.v[0] = pr; m.pt[0] = m.t; m.t = ty;
      m.we = 1; m.wd = 0;
      m.tg_pc = "R2"; m.tg_ca = "R3"; m.tg_st = "R4"; m.tg_ty = "R5"; m.tg_out = "R4";
    end else if (ret) begin
      m.rv = 1; m.rpc = m.e[0]; m.rpr = m.v[0]; m.we = 1; m.wd = m.p[0]; m.t = m.pt[0];
      for (int i = 0; i < 2; i++) begin
        m.e[i] = m.e[i+1]; m.c[i] = m.c[i+1]; m.p[i] = m.p[i+1];
        m.v[i] = m.v[i+1]; m.pt[i] = m.pt[i+1];
      end
      m.e[2] = 0; m.c[2] = 0; m.p[2] = 1; m.v[2] = 2'b11; m.pt[2] = 0;
      m.tg_pc = "R7"; m.tg_ca = "R7"; m.tg_st = "R7"; m.tg_ty = "R6"; m.tg_out = "R6";
    end else begin
      m.tg_pc = "R10"; m.tg_ca = "R10"; m.tg_st = "R10"; m.tg_ty = "R10"; m.tg_out = "R10";
    end
    if (tag != "") begin
      m.tg_pc = tag; m.tg_ca = tag; m.tg_st = tag; m.tg_ty = tag; m.tg_out = tag;
    end
    q.push_back(m);
  endtask

  always @(posedge clk) begin
    #1;
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(e.tg_pc, "epc", {epc_sv2, epc}, {e.e[2], e.e[0]});
      chk(e.tg_pc, "epc_sv1", 64'(epc_sv1), 64'(e.e[1]));
      chk(e.tg_ca, "cause levels", 64'({cause_sv2, cause_sv1, cause}), 64'({e.c[2], e.c[1], e.c[0]}));
      chk(e.tg_st, "pie/ppriv levels", 64'({pie_sv2, pie_sv1, pie, ppriv_sv2, ppriv_sv1, ppriv}),
          64'({e.p[2], e.p[1], e.p[0], e.v[2], e.v[1], e.v[0]}));
      chk(e.tg_ty, "type levels", 64'({ttype, pttype_sv2, pttype_sv1, pttype}),
          64'({e.t, e.pt[2], e.pt[1], e.pt[0]}));
      chk(e.tg_out, "valid/mie", 64'({ret_valid, mie_we, mie_wdata & mie_we}),
          64'({e.rv, e.we, e.wd & e.we}));
      if (e.rv) chk(e.tg_out, "ret pc/priv", 64'({ret_priv, ret_pc}), 64'({e.rpr, e.rpc}));
    end
  end

  initial begin
    for (int i = 0; i < 3; i++) begin
      m.e[i] = 0; m.c[i] = 0; m.p[i] = 1; m.v[i] = 2'b11; m.pt[i] = 0;
    end
    m.t = 0; m.rv = 0; m.rpc = 0; m.rpr = 2'b11; m.we = 0; m.wd = 0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    op(0, 0, 0, 0, 0, 0, 0, "R1");
    op(1, 0, 32'h100, 12'd3, 2'd1, 1, 2'b00, "");
    op(1, 0, 32'h200, 12'd7, 2'd2, 0, 2'b11, "");
    op(1, 0, 32'h300, 12'd11, 2'd1, 0, 2'b11, "");
    op(1, 0, 32'h400, 12'd13, 2'd3, 1, 2'b01, "R9");
    op(0, 0, 32'hdead, 12'd99, 2'd2, 1, 2'b00, "");
    op(1, 1, 32'h500, 12'd5, 2'd2, 0, 2'b11, "R8");
    op(0, 1, 0, 0, 0, 0, 0, "");
    op(0, 1, 0, 0, 0, 0, 0, "R9");
    op(0, 1, 0, 0, 0, 0, 0, "");
    op(0, 1, 0, 0, 0, 0, 0, "R9");
    op(0, 1, 0, 0, 0, 0, 0, "");
    op(1, 0, 32'h600, 12'd2, 2'd1, 1, 2'b00, "");
    op(0, 1, 0, 0, 0, 0, 0, "");
    op(0, 0, 0, 0, 0, 0, 0, "");
    repeat (4) @(posedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule